// File: doc/BRIEF.md
# Write Protection Guard for a Four-Block Memory Array

This block holds the protection state of a serial memory device and decides, request by request, whether a write-type operation may go ahead. The state is a two-bit protection level, a hardware-lock enable bit, and a volatile write-enable latch. A command decoder presents a decoded request code, a target address, the status byte it wants to write, and a commit strobe. The guard answers with a combinational permit. On the commit strobe it applies the request's effect on its own state, but only if that request was permitted. It also produces the status byte that a status read returns, and a mask of the blocks that a whole-array erase may clear.

The array is 2^ADDR_W bytes split into four equal blocks. The two top address bits select the block. The protection level covers none of the array, the top quarter, the top half, or all of it. A second lock is armed when the enable bit is set and the active-low protect pin is low. That lock freezes the status register, including its own enable bit. The sequencer that times program and erase cycles drives the busy flag and pulses the cycle-completion input.

Top module: `wpg_guard`

## Requirements
- R1: After reset the write-enable latch, the level bits and the lock-enable bit are all 0, so the idle status byte reads 0x00.
- R2: On a commit while not busy, request code 5 sets the latch (status bit 1) and code 6 clears it. Code 6 works whatever the level of the protect pin.
- R3: A block is locked when the level (status bits 3:2) is 3, or it is 2 and address bit ADDR_W-1 is 1, or it is 1 and address bits ADDR_W-1 and ADDR_W-2 are both 1.
- R4: Program (code 1) and sector/block erase (code 2) are permitted only when the latch is set, the target block is unlocked and busy is low. A denied request leaves all state unchanged.
- R5: Whole-array erase (code 3) is permitted when the latch is set, busy is low and the level is not 3. The erase mask output bit b is 1 exactly when block b is unlocked.
- R6: A status write (code 4) is permitted when the latch is set, busy is low and the hardware lock is not active. The lock is active when the enable bit is 1 and the protect pin is low. A permitted commit loads data bit 7 into the enable bit and data bits 3:2 into the level. The other data bits are ignored.
- R7: The protect pin is sampled at the commit. If it is low there with the enable bit set, the status write is dropped. A pin fall after the commit leaves the stored values unchanged.
- R8: A cycle-completion pulse clears the latch. When it coincides with a code-5 commit, the clear wins.
- R9: While busy is high, the status byte reads 0xFF, permit is 0 and every commit is ignored.
- R10: While idle, status bits 6:4 and bit 0 read 0.
- R11: Code 0 (none) and code 7 (reserved) never give a permit. Codes 5 and 6 are permitted whenever busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_kind | input | 3 | Decoded request code |
| req_addr | input | ADDR_W | Target byte address |
| req_wdata | input | 8 | Status byte for a status write |
| req_commit | input | 1 | Applies the presented request if permitted |
| wp_n | input | 1 | Active-low hardware protect pin |
| busy_in | input | 1 | Internal write cycle in progress |
| cycle_done | input | 1 | Pulse when an internal write cycle completes |
| permit | output | 1 | Presented request may proceed |
| status_out | output | 8 | Status byte for status reads |
| erase_mask | output | 4 | Blocks a whole-array erase may clear |

## Verification
Two pairs of events can fall in the same cycle. The first is a status-write commit and a falling protect pin. The second is a latch-set commit and a cycle-completion pulse. Directed steps drive each pair on one edge. The random loop also lands on them by chance, because the pin, the completion pulse and the commit are drawn independently. The status byte read back on the next idle cycle must show the dropped write or the cleared latch that the requirements call for.

// File: rtl/wpg_pkg.sv
package wpg_pkg;
   typedef enum logic [2:0] {
      RQ_NONE    = 3'd0,
      RQ_PROG    = 3'd1,
      RQ_ERASE   = 3'd2,
      RQ_CHIP    = 3'd3,
      RQ_STWR    = 3'd4,
      RQ_WEN_SET = 3'd5,
      RQ_WEN_CLR = 3'd6,
      RQ_RSVD    = 3'd7
   } req_e;

   localparam int unsigned LVL_W  = 2;
   localparam int unsigned NBLK   = 4;
   localparam int unsigned SR_W   = 8;
   localparam int unsigned SR_LOCK_BIT = 7;
   localparam int unsigned SR_LVL_LO   = 2;
   localparam int unsigned SR_WEL_BIT  = 1;
endpackage

// File: rtl/wpg_range.sv
module wpg_range
   import wpg_pkg::*;
#(
   parameter int unsigned ADDR_W = 17
) (
   input  logic [LVL_W-1:0]  level,
   input  logic [ADDR_W-1:0] addr,
   output logic [NBLK-1:0]   blk_locked,
   output logic              addr_locked
);
   localparam int unsigned BSEL_W = $clog2(NBLK);

   if (ADDR_W < BSEL_W + 1) begin : g_bad_width
      $error("wpg_range: ADDR_W too small for four blocks");
   end

   logic [BSEL_W-1:0] bsel;
   logic              unused_addr_lo;

   assign bsel           = addr[ADDR_W-1 -: BSEL_W];
   assign unused_addr_lo = ^addr[ADDR_W-BSEL_W-1:0];

   // Level n locks the top n of the upper blocks: 1 -> top quarter,
   // 2 -> top half, 3 -> everything.
   for (genvar b = 0; b < NBLK; b++) begin : g_blk
      localparam int unsigned FROM_TOP = NBLK - b;
      always_comb begin
         unique case (level)
            2'd0:    blk_locked[b] = 1'b0;
            2'd1:    blk_locked[b] = (FROM_TOP <= 1);
            2'd2:    blk_locked[b] = (FROM_TOP <= 2);
            default: blk_locked[b] = 1'b1;
         endcase
      end
   end

   assign addr_locked = blk_locked[bsel];
endmodule

// File: rtl/wpg_latch.sv
module wpg_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   input  logic auto_clr_i,
   output logic wel_o
);
   // Priority: completion clear, then explicit clear, then set.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          wel_o <= 1'b0;
      else if (auto_clr_i) wel_o <= 1'b0;
      else if (clr_i)      wel_o <= 1'b0;
      else if (set_i)      wel_o <= 1'b1;
   end
endmodule

// File: rtl/wpg_statreg.sv
module wpg_statreg
   import wpg_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [SR_W-1:0]  wdata_i,
   input  logic             busy_i,
   input  logic             wel_i,
   output logic [LVL_W-1:0] level_o,
   output logic             lock_en_o,
   output logic [SR_W-1:0]  status_o
);
   logic unused_wdata;
   assign unused_wdata = ^{wdata_i[6:4], wdata_i[1:0]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level_o   <= '0;
         lock_en_o <= 1'b0;
      end else if (load_i) begin
         level_o   <= wdata_i[SR_LVL_LO +: LVL_W];
         lock_en_o <= wdata_i[SR_LOCK_BIT];
      end
   end

   always_comb begin
      status_o = '0;
      if (busy_i) begin
         status_o = '1;
      end else begin
         status_o[SR_LOCK_BIT]            = lock_en_o;
         status_o[SR_LVL_LO +: LVL_W]     = level_o;
         status_o[SR_WEL_BIT]             = wel_i;
      end
   end
endmodule

// File: rtl/wpg_guard.sv
module wpg_guard
   import wpg_pkg::*;
#(
   parameter int unsigned ADDR_W = 17
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        req_kind,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [7:0]        req_wdata,
   input  logic              req_commit,
   input  logic              wp_n,
   input  logic              busy_in,
   input  logic              cycle_done,
   output logic              permit,
   output logic [7:0]        status_out,
   output logic [3:0]        erase_mask
);
   req_e             kind;
   logic             wel_q;
   logic [LVL_W-1:0] bp_q;
   logic             wpen_q;
   logic [NBLK-1:0]  blk_locked;
   logic             addr_locked;
   logic             idle;
   logic             hw_lock;
   logic             apply;

   assign kind    = req_e'(req_kind);
   assign idle    = !busy_in;
   assign hw_lock = wpen_q && !wp_n;

   wpg_range #(.ADDR_W(ADDR_W)) u_range (
      .level       (bp_q),
      .addr        (req_addr),
      .blk_locked  (blk_locked),
      .addr_locked (addr_locked)
   );

   always_comb begin
      unique case (kind)
         RQ_PROG, RQ_ERASE:     permit = wel_q && idle && !addr_locked;
         RQ_CHIP:               permit = wel_q && idle && (bp_q != 2'd3);
         RQ_STWR:               permit = wel_q && idle && !hw_lock;
         RQ_WEN_SET, RQ_WEN_CLR: permit = idle;
         default:               permit = 1'b0;
      endcase
   end

   assign apply      = req_commit && permit;
   assign erase_mask = ~blk_locked;

   wpg_latch u_latch (
      .clk        (clk),
      .rst_n      (rst_n),
      .set_i      (apply && kind == RQ_WEN_SET),
      .clr_i      (apply && kind == RQ_WEN_CLR),
      .auto_clr_i (cycle_done),
      .wel_o      (wel_q)
   );

   wpg_statreg u_stat (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (apply && kind == RQ_STWR),
      .wdata_i   (req_wdata),
      .busy_i    (busy_in),
      .wel_i     (wel_q),
      .level_o   (bp_q),
      .lock_en_o (wpen_q),
      .status_o  (status_out)
   );
endmodule

// File: rtl/wpg_guard_chk.sv
module wpg_guard_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [2:0] req_kind,
   input logic       req_commit,
   input logic       wp_n,
   input logic       busy_in,
   input logic       cycle_done,
   input logic       permit,
   input logic [7:0] status_out,
   input logic       wel_q,
   input logic [1:0] bp_q,
   input logic       wpen_q
);
   assert_busy_ff_R9: assert property (@(posedge clk) disable iff (!rst_n)
      busy_in |-> (status_out == 8'hFF && !permit));

   assert_busy_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_in && !cycle_done) |=> ($stable(wel_q) && $stable(bp_q) && $stable(wpen_q)));

   assert_idle_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_in |-> (status_out[6:4] == 3'b000 && !status_out[0]));

   assert_autoclr_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cycle_done |=> !wel_q);

   assert_wren_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_commit && req_kind == 3'd5 && !busy_in && !cycle_done) |=> wel_q);

   assert_wrdi_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_commit && req_kind == 3'd6 && !busy_in) |=> !wel_q);

   assert_hwlock_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_kind == 3'd4 && wpen_q && !wp_n) |-> !permit);

   assert_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_commit && req_kind == 3'd4 && !permit) |=> ($stable(bp_q) && $stable(wpen_q)));

   assert_rsvd_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (req_kind == 3'd0 || req_kind == 3'd7) |-> !permit);
endmodule

bind wpg_guard wpg_guard_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_kind   (req_kind),
   .req_commit (req_commit),
   .wp_n       (wp_n),
   .busy_in    (busy_in),
   .cycle_done (cycle_done),
   .permit     (permit),
   .status_out (status_out),
   .wel_q      (wel_q),
   .bp_q       (bp_q),
   .wpen_q     (wpen_q)
);

// File: tb/wpg_guard_bench.sv
module wpg_guard_bench;
   localparam int AW = 17;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [2:0]    req_kind = '0;
   logic [AW-1:0] req_addr = '0;
   logic [7:0]    req_wdata = '0;
   logic          req_commit = 1'b0;
   logic          wp_n = 1'b1;
   logic          busy_in = 1'b0;
   logic          cycle_done = 1'b0;
   logic          permit;
   logic [7:0]    status_out;
   logic [3:0]    erase_mask;

   int n_run = 0;
   int n_fail = 0;

   // bench model state
   logic       m_wel = 1'b0;
   logic [1:0] m_bp = 2'd0;
   logic       m_wpen = 1'b0;

   always #4 clk = ~clk;

   wpg_guard #(.ADDR_W(AW)) u_wpg_guard (
      .clk(clk), .rst_n(rst_n), .req_kind(req_kind), .req_addr(req_addr),
      .req_wdata(req_wdata), .req_commit(req_commit), .wp_n(wp_n),
      .busy_in(busy_in), .cycle_done(cycle_done), .permit(permit),
      .status_out(status_out), .erase_mask(erase_mask)
   );

   function automatic logic blk_lock(logic [1:0] lv, int b);
      return (lv == 2'd3) || (lv == 2'd2 && b >= 2) || (lv == 2'd1 && b == 3);
   endfunction

   function automatic logic exp_permit(logic [2:0] k, logic [AW-1:0] a, logic wp, logic bz);
      if (bz) return 1'b0;
      case (k)
         3'd1, 3'd2: return m_wel && !blk_lock(m_bp, int'(a[AW-1 -: 2]));
         3'd3:       return m_wel && (m_bp != 2'd3);
         3'd4:       return m_wel && !(m_wpen && !wp);
         3'd5, 3'd6: return 1'b1;
         default:    return 1'b0;
      endcase
   endfunction

   function automatic logic [7:0] exp_status(logic bz);
      return bz ? 8'hFF : {m_wpen, 3'b000, m_bp, m_wel, 1'b0};
   endfunction

   function automatic logic [3:0] exp_mask();
      logic [3:0] m;
      for (int b = 0; b < 4; b++) m[b] = !blk_lock(m_bp, b);
      return m;
   endfunction

   function automatic string tag_of(logic [2:0] k, logic bz);
      if (bz) return "R9";
      case (k)
         3'd1, 3'd2: return "R4";
         3'd3:       return "R5";
         3'd4:       return "R6";
         3'd5, 3'd6: return "R2";
         default:    return "R11";
      endcase
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // One cycle: drive at falling edge, check outputs, then update model at rising edge.
   task automatic step(logic [2:0] k, logic [AW-1:0] a, logic [7:0] d, logic wp,
                       logic bz, logic cm, logic dn, string req);
      logic p;
      @(negedge clk);
      req_kind = k; req_addr = a; req_wdata = d; wp_n = wp;
      busy_in = bz; req_commit = cm; cycle_done = dn;
      #1;
      p = exp_permit(k, a, wp, bz);
      chk(req, {31'd0, permit}, {31'd0, p});
      chk(bz ? "R9" : "R10", {24'd0, status_out}, {24'd0, exp_status(bz)});
      chk("R5", {28'd0, erase_mask}, {28'd0, exp_mask()});
      @(posedge clk);
      if (cm && p) begin
         if (k == 3'd5) m_wel = 1'b1;
         if (k == 3'd6) m_wel = 1'b0;
         if (k == 3'd4) begin m_wpen = d[7]; m_bp = d[3:2]; end
      end
      if (dn) m_wel = 1'b0;
   endtask

   task automatic idle_look(string req);
      step(3'd0, '0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, req);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin : main
      int unsigned seed_sink;
      seed_sink = $urandom(32'h1D5A7);
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1: reset state
      @(negedge clk); #1;
      chk("R1", {24'd0, status_out}, 32'h00);
      chk("R1", {31'd0, permit}, 32'h0);
      // R4: program without latch refused
      step(3'd1, 17'h00010, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, "R4");
      // R2: set latch
      step(3'd5, '0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, "R2");
      idle_look("R2");
      // R6: status write level 3 with lock enable, unused data bits set
      step(3'd4, '0, 8'hFF, 1'b1, 1'b0, 1'b1, 1'b0, "R6");
      idle_look("R6");
      // R3: level 3 locks address 0; R5: chip erase refused
      step(3'd1, 17'h00000, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, "R3");
      step(3'd3, 17'h00000, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, "R5");
      // R7: pin low at commit drops the write
      step(3'd4, '0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, "R7");
      idle_look("R7");
      // R2: clear latch while pin low
      step(3'd6, '0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, "R2");
      idle_look("R2");
      // R8: set and completion in the same cycle
      step(3'd5, '0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1, "R8");
      idle_look("R8");
      // R9: busy, set ignored
      step(3'd5, '0, 8'h00, 1'b1, 1'b1, 1'b1, 1'b0, "R9");
      idle_look("R9");
      // R3: level 1 then level 2 boundaries, pin high
      step(3'd5, '0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, "R2");
      step(3'd4, '0, 8'h04, 1'b1, 1'b0, 1'b1, 1'b0, "R6");
      step(3'd1, 17'h17FFF, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, "R3");
      step(3'd2, 17'h18000, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, "R3");
      step(3'd4, '0, 8'h88, 1'b1, 1'b0, 1'b1, 1'b0, "R6");
      // R7: pin falls the cycle after commit, values kept
      step(3'd0, '0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, "R7");
      step(3'd1, 17'h0FFFF, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, "R3");
      step(3'd1, 17'h10000, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, "R3");
      step(3'd3, 17'h00000, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, "R5");
      step(3'd7, '0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, "R11");
      // constrained random mix
      for (int i = 0; i < 3000; i++) begin
         logic [2:0] k; logic bz; logic dn;
         k  = 3'($urandom_range(0, 7));
         bz = ($urandom_range(0, 4) == 0);
         dn = bz ? ($urandom_range(0, 3) == 0) : ($urandom_range(0, 19) == 0);
         step(k, AW'($urandom), 8'($urandom), 1'($urandom), bz,
              ($urandom_range(0, 9) < 6), dn, tag_of(k, bz));
      end
      idle_look("R10");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule